// File: doc/BRIEF.md
# Receive Ring Page Pointer Unit

This unit steers incoming frame bytes into a circular set of 256-byte pages inside a 64 KB local buffer memory. Software programs four page-granular registers: the first page of the ring, the page just past its end, the committed write page and the guard page that the reader has not yet released. Each holds only address bits 15:8, because every page is aligned on a 256-byte boundary.

For every accepted byte the unit presents a 16-bit write address made of the live page and a byte offset. When a page fills it chains to the following page, folding back to the first page of the ring at the ring's end, and it refuses to enter the guard page. In that case it raises an overflow abort and stops advancing. A frame that ends well moves the committed page past everything it used. A frame that ends badly, or one that had aborted, rewinds the write pointer to the committed page, so the failed bytes are dropped. The live address can also be read one byte at a time through a small read port.

Top module: `rx_ring_pager`

## Requirements
- R1: After reset all four page registers are 0, the write address is 0x0000, the overflow abort is low and the read byte is 0.
- R2: A register write with select code 0 (ring first page) also loads the committed page with the same value, moves the write address to {value, 0x00} and clears the abort.
- R3: Each byte-valid cycle that is not aborted and does not end a page adds 1 to address bits 7:0 and leaves bits 15:8 unchanged.
- R4: A byte accepted at offset 0xFF moves the write address to {next page, 0x00}, where next page is the current page plus 1 (modulo 256).
- R5: When the current page plus 1 equals the ring end page (select code 1), the next page is the ring first page instead.
- R6: When the next page equals the guard page (select code 3), the abort rises in the cycle after that byte, the address stays frozen and later bytes are ignored until the frame ends.
- R7: A frame-bad pulse returns the write address to {committed page, 0x00} and clears the abort.
- R8: A frame-good pulse with no abort sets the committed page and the write page to the page after the last one written: the current page if the offset is 0x00, otherwise its next page. The offset becomes 0x00.
- R9: A frame-good pulse while aborted acts as a frame-bad pulse: the address rewinds to {committed page, 0x00} and the committed page is kept.
- R10: With read-high at 0 the read byte shows address bits 7:0. With read-high at 1 it shows bits 15:8.
- R11: A register write with select code 2 sets the committed page and moves the write address to {value, 0x00}. Writes with select codes 1 and 3 leave the write address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Page register write strobe |
| reg_sel | input | 2 | Register select: 0 first, 1 end, 2 committed, 3 guard |
| reg_wdata | input | 8 | Page value written |
| byte_vld | input | 1 | One frame byte is written at wr_addr this cycle |
| frame_good | input | 1 | Frame finished without error |
| frame_bad | input | 1 | Frame finished with an error |
| rd_hi | input | 1 | Selects the high byte of the live address on rd_byte |
| wr_addr | output | 16 | Local memory write address for the current byte |
| ovf_abort | output | 1 | Ring overrun: the frame is being dropped |
| rd_byte | output | 8 | One byte of the live write address |

## Verification
The properties assume that page registers change only between frames, so every sequence check is gated off in cycles that carry a register write. They also assume that the end page lies above the first page, which keeps the chained pages inside the ring. The stimulus keeps to this: it writes the end and guard pages before the first page, which restarts the pointer, and it only reprograms after a frame-good or frame-bad pulse. Frame ends never share a cycle with a byte, although the unit still gives them a defined priority.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    parameter int RXR_PG_W  = 8;
    parameter int RXR_OFS_W = 8;
    localparam int RXR_ADDR_W = RXR_PG_W + RXR_OFS_W;

    typedef logic [RXR_PG_W-1:0]  page_t;
    typedef logic [RXR_OFS_W-1:0] ofs_t;

    typedef enum logic [1:0] {
        SEL_FIRST = 2'd0,
        SEL_END   = 2'd1,
        SEL_COMMIT = 2'd2,
        SEL_GUARD = 2'd3
    } ring_sel_e;

    typedef struct packed {
        page_t first;
        page_t last_x;
        page_t commit;
        page_t guard;
    } ring_regs_t;

    function automatic page_t ring_next(page_t cur, page_t first, page_t last_x);
        page_t inc;
        inc = cur + page_t'(1);
        return (inc == last_x) ? first : inc;
    endfunction
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  ring_sel_e   reg_sel,
    input  page_t       reg_wdata,
    input  logic        commit_ld,
    input  page_t       commit_val,
    output ring_regs_t  regs,
    output logic        ptr_ld,
    output page_t       ptr_val
);
    ring_regs_t r_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else if (reg_we) begin
            unique case (reg_sel)
                SEL_FIRST: begin
                    r_q.first  <= reg_wdata;
                    r_q.commit <= reg_wdata;
                end
                SEL_END:    r_q.last_x <= reg_wdata;
                SEL_COMMIT: r_q.commit <= reg_wdata;
                SEL_GUARD:  r_q.guard  <= reg_wdata;
                default: ;
            endcase
        end else if (commit_ld) begin
            r_q.commit <= commit_val;
        end
    end

    always_comb begin
        regs    = r_q;
        ptr_ld  = reg_we && (reg_sel == SEL_FIRST || reg_sel == SEL_COMMIT);
        ptr_val = reg_wdata;
    end
endmodule

// File: rtl/rxr_wrptr.sv
module rxr_wrptr
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ring_regs_t  regs,
    input  logic        ptr_ld,
    input  page_t       ptr_val,
    input  logic        byte_vld,
    input  logic        frame_good,
    input  logic        frame_bad,
    output page_t       page,
    output ofs_t        ofs,
    output logic        abort,
    output logic        commit_ld,
    output page_t       commit_val
);
    page_t page_q;
    ofs_t  ofs_q;
    logic  abort_q;
    page_t nxt;
    logic  rewind;

    always_comb begin
        nxt        = ring_next(page_q, regs.first, regs.last_x);
        rewind     = frame_bad || (frame_good && abort_q);
        commit_val = (ofs_q == '0) ? page_q : nxt;
        commit_ld  = frame_good && !abort_q && !ptr_ld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q  <= '0;
            ofs_q   <= '0;
            abort_q <= 1'b0;
        end else if (ptr_ld) begin
            page_q  <= ptr_val;
            ofs_q   <= '0;
            abort_q <= 1'b0;
        end else if (rewind) begin
            page_q  <= regs.commit;
            ofs_q   <= '0;
            abort_q <= 1'b0;
        end else if (frame_good) begin
            page_q  <= commit_val;
            ofs_q   <= '0;
        end else if (byte_vld && !abort_q) begin
            if (ofs_q == '1) begin
                if (nxt == regs.guard) begin
                    abort_q <= 1'b1;
                end else begin
                    page_q <= nxt;
                    ofs_q  <= '0;
                end
            end else begin
                ofs_q <= ofs_q + ofs_t'(1);
            end
        end
    end

    assign page  = page_q;
    assign ofs   = ofs_q;
    assign abort = abort_q;
endmodule

// File: rtl/rxr_readout.sv
module rxr_readout
    import rxr_pkg::*;
(
    input  logic                  rd_hi,
    input  logic [RXR_ADDR_W-1:0] addr,
    output logic [7:0]            rd_byte
);
    localparam int NBYTES = (RXR_ADDR_W + 7) / 8;
    logic [NBYTES*8-1:0] padded;
    logic [7:0] lanes [NBYTES];

    assign padded = {{(NBYTES*8-RXR_ADDR_W){1'b0}}, addr};

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = padded[g*8 +: 8];
    end

    assign rd_byte = rd_hi ? lanes[NBYTES-1] : lanes[0];
endmodule

// File: rtl/rx_ring_pager.sv
module rx_ring_pager
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        byte_vld,
    input  logic        frame_good,
    input  logic        frame_bad,
    input  logic        rd_hi,
    output logic [15:0] wr_addr,
    output logic        ovf_abort,
    output logic [7:0]  rd_byte
);
    ring_regs_t regs;
    logic       ptr_ld;
    page_t      ptr_val;
    logic       commit_ld;
    page_t      commit_val;
    page_t      page;
    ofs_t       ofs;
    logic       abort;

    rxr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_sel    (ring_sel_e'(reg_sel)),
        .reg_wdata  (page_t'(reg_wdata)),
        .commit_ld  (commit_ld),
        .commit_val (commit_val),
        .regs       (regs),
        .ptr_ld     (ptr_ld),
        .ptr_val    (ptr_val)
    );

    rxr_wrptr u_wrptr (
        .clk        (clk),
        .rst        (rst),
        .regs       (regs),
        .ptr_ld     (ptr_ld),
        .ptr_val    (ptr_val),
        .byte_vld   (byte_vld),
        .frame_good (frame_good),
        .frame_bad  (frame_bad),
        .page       (page),
        .ofs        (ofs),
        .abort      (abort),
        .commit_ld  (commit_ld),
        .commit_val (commit_val)
    );

    assign wr_addr   = 16'({page, ofs});
    assign ovf_abort = abort;

    rxr_readout u_rd (
        .rd_hi   (rd_hi),
        .addr    ({page, ofs}),
        .rd_byte (rd_byte)
    );
endmodule

// File: rtl/rx_ring_pager_chk.sv
module rx_ring_pager_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic        byte_vld,
    input logic        frame_good,
    input logic        frame_bad,
    input logic [15:0] wr_addr,
    input logic        ovf_abort
);
    logic quiet;
    assign quiet = !reg_we && !frame_good && !frame_bad;

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (rst)
        quiet && byte_vld && !ovf_abort && wr_addr[7:0] != 8'hFF
        |=> wr_addr == $past(wr_addr) + 16'd1); // R3

    AST_PAGE_LINK: assert property (@(posedge clk) disable iff (rst)
        quiet && byte_vld && !ovf_abort && wr_addr[7:0] == 8'hFF
        |=> wr_addr[7:0] == 8'h00 || ovf_abort); // R4

    AST_ABORT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        quiet && ovf_abort |=> ovf_abort && $stable(wr_addr)); // R6

    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_abort) |-> $past(byte_vld) && $past(wr_addr[7:0]) == 8'hFF); // R6

    AST_BAD_REWIND: assert property (@(posedge clk) disable iff (rst)
        frame_bad |=> wr_addr[7:0] == 8'h00 && !ovf_abort); // R7

    AST_GOOD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        frame_good |=> wr_addr[7:0] == 8'h00 && !ovf_abort); // R8
endmodule

bind rx_ring_pager rx_ring_pager_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .byte_vld   (byte_vld),
    .frame_good (frame_good),
    .frame_bad  (frame_bad),
    .wr_addr    (wr_addr),
    .ovf_abort  (ovf_abort)
);

// File: tb/tb_rx_ring_pager.sv
`timescale 1ns/1ps
module tb_rx_ring_pager;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        byte_vld = 1'b0;
    logic        frame_good = 1'b0;
    logic        frame_bad = 1'b0;
    logic        rd_hi = 1'b0;
    logic [15:0] wr_addr;
    logic        ovf_abort;
    logic [7:0]  rd_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_first = 0, m_end = 0, m_commit = 0, m_guard = 0, m_pg = 0, m_ofs = 0;
    logic       m_abort = 0;

    always #4 clk = ~clk;

    rx_ring_pager dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .byte_vld(byte_vld), .frame_good(frame_good),
        .frame_bad(frame_bad), .rd_hi(rd_hi), .wr_addr(wr_addr),
        .ovf_abort(ovf_abort), .rd_byte(rd_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_next(input logic [7:0] p);
        logic [7:0] inc;
        inc = p + 8'd1;
        return (inc == m_end) ? m_first : inc;
    endfunction

    task automatic chk_state(input string tag);
        chk(tag, {15'd0, ovf_abort, wr_addr}, {15'd0, m_abort, m_pg, m_ofs});
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] v);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            2'd0: begin m_first = v; m_commit = v; m_pg = v; m_ofs = 0; m_abort = 0; end
            2'd1: m_end = v;
            2'd2: begin m_commit = v; m_pg = v; m_ofs = 0; m_abort = 0; end
            default: m_guard = v;
        endcase
        chk_state(sel == 2'd0 ? "R2" : "R11");
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1;
            @(negedge clk);
            byte_vld = 1'b0;
            if (!m_abort) begin
                if (m_ofs == 8'hFF) begin
                    if (m_next(m_pg) == m_guard) m_abort = 1;
                    else begin m_pg = m_next(m_pg); m_ofs = 0; end
                end else m_ofs++;
            end
            chk_state(m_abort ? "R6" : (m_ofs == 0 ? "R4/R5" : "R3"));
        end
    endtask

    task automatic end_good();
        frame_good = 1'b1;
        @(negedge clk);
        frame_good = 1'b0;
        if (m_abort) m_pg = m_commit;
        else begin
            m_commit = (m_ofs == 0) ? m_pg : m_next(m_pg);
            m_pg = m_commit;
        end
        m_ofs = 0; m_abort = 0;
        chk_state("R8/R9");
    endtask

    task automatic end_bad();
        frame_bad = 1'b1;
        @(negedge clk);
        frame_bad = 1'b0;
        m_pg = m_commit; m_ofs = 0; m_abort = 0;
        chk_state("R7");
    endtask

    task automatic chk_rd();
        rd_hi = 1'b0; #1;
        chk("R10 low", {24'd0, rd_byte}, {24'd0, m_ofs});
        rd_hi = 1'b1; #1;
        chk("R10 high", {24'd0, rd_byte}, {24'd0, m_pg});
        rd_hi = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 addr", {16'd0, wr_addr}, 32'h0);
        chk("R1 abort", {31'd0, ovf_abort}, 32'h0);
        chk("R1 rd", {24'd0, rd_byte}, 32'h0);

        wr_reg(2'd1, 8'h14);
        wr_reg(2'd3, 8'h0F);
        wr_reg(2'd0, 8'h10);
        chk("R2 addr", {16'd0, wr_addr}, 32'h1000);
        push(10);
        chk("R3 addr", {16'd0, wr_addr}, 32'h100A);
        chk_rd();
        end_bad();
        chk("R7 addr", {16'd0, wr_addr}, 32'h1000);
        push(300);
        chk("R4 addr", {16'd0, wr_addr}, 32'h112C);
        end_good();
        chk("R8 addr", {16'd0, wr_addr}, 32'h1200);
        push(256);
        end_good();
        chk("R8 exact page", {16'd0, wr_addr}, 32'h1300);
        push(300);
        chk("R5 wrap", {16'd0, wr_addr}, 32'h102C);
        end_good();
        chk_rd();
        wr_reg(2'd3, 8'h13);
        chk("R11 guard no move", {16'd0, wr_addr}, 32'h1100);
        push(600);
        chk("R6 abort", {31'd0, ovf_abort}, 32'h1);
        chk("R6 frozen", {16'd0, wr_addr}, 32'h12FF);
        end_good();
        chk("R9 rewind", {16'd0, wr_addr}, 32'h1100);
        push(520);
        end_bad();
        chk("R7 after abort", {16'd0, wr_addr}, 32'h1100);
        wr_reg(2'd2, 8'h12);
        chk("R11 commit", {16'd0, wr_addr}, 32'h1200);
        wr_reg(2'd1, 8'h16);
        chk("R11 end no move", {16'd0, wr_addr}, 32'h1200);

        // sweep of ring sizes and guard positions (R4 R5 R6)
        for (int n = 1; n <= 4; n++) begin
            for (int k = 0; k <= n; k++) begin
                wr_reg(2'd1, 8'(8'h20 + n));
                wr_reg(2'd3, (k == n) ? 8'h1F : 8'(8'h20 + k));
                wr_reg(2'd0, 8'h20);
                push((2 * n + 1) * 256);
                end_bad();
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule